// File: doc/BRIEF.md
# Four-State Power Mode Controller

This block sequences a device among four power modes and drives the per-domain clock enables and the fast/slow clock select that follow from each mode. Four clock domains are controlled: the CPU, the peripheral group, the power controller itself, and the timing/watchdog block. In the full-speed mode every domain runs on the high-frequency clock. In the reduced-speed mode the CPU and peripherals keep running on the slow clock. In the sleep mode only the power controller and the timing/watchdog block keep their slow clock. In the stop mode every clock is gated, while register and memory contents are retained.

Software asks for a mode through a small valid/ready request port. A request is taken on a cycle where both `req_valid_i` and `req_ready_o` are high. Ready is low while a transition is in flight, and the requester must hold its request until it is taken. A request that is not legal from the current mode is still taken and then dropped. A single synchronized wake-up input returns the device from sleep or stop to full speed. The return from stop first waits a programmable number of slow-clock periods, so that the oscillator can settle. The slow-clock periods arrive as a one-cycle tick input. Whenever the clock select has to change, the controller closes every enable first, so that no domain sees a partial clock pulse.

Top module: `pmc_top`

## Requirements
- R1: After reset the mode output is full speed (2'b00), all four domain enables are 1, the clock select is 0 (fast) and `req_ready_o` is 1.
- R2: Mode codes are full speed 2'b00, reduced speed 2'b01, sleep 2'b10 and stop 2'b11. The enable bits are bit 0 CPU, bit 1 peripherals, bit 2 power controller and bit 3 timing/watchdog. In steady state the enables are 4'b1111 in full speed and in reduced speed, 4'b1100 in sleep and 4'b0000 in stop. The clock select is 1 (slow) in every mode except full speed.
- R3: A request is taken only on a cycle with `req_valid_i` and `req_ready_o` both high. `req_ready_o` is low from the cycle after a transition starts until the cycle in which the new mode is in force. A request offered while ready is low has no effect.
- R4: A taken request is acted on only when the current mode is full speed or reduced speed and the requested mode differs from the current one. Any other taken request leaves every output unchanged.
- R5: A transition between two modes that use the same clock (reduced speed to sleep, reduced speed to stop) shows the new mode and its enables on the cycle right after the request is taken.
- R6: A transition that changes the clock select runs in three steps. After the starting edge, all enables are 0 and the select keeps its old value. After the next edge, the select takes its new value and the enables are still 0. After the third edge, the new mode and its enables appear.
- R7: The clock select never changes unless the enables are all 0 both in the cycle before the change and in the cycle of the change.
- R8: A wake-up in steady sleep starts the R6 sequence back to full speed. A wake-up in full speed or in reduced speed, or while a transition is in flight, has no effect.
- R9: A wake-up in steady stop waits until `slow_tick_i` has pulsed `settle_len_i` times, then starts the R6 sequence back to full speed. With `settle_len_i` = 0 the R6 sequence starts at once. While the controller waits, the mode stays stop and the enables stay 0.
- R10: In stop, a request is taken but ignored, and the controller leaves stop only through R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Mode request offered |
| req_mode_i | input | 2 | Requested mode code |
| req_ready_o | output | 1 | Controller can take a request |
| wake_i | input | 1 | Synchronized wake-up event |
| slow_tick_i | input | 1 | One-cycle pulse per slow-clock period |
| settle_len_i | input | STAB_W | Slow periods to wait when leaving stop |
| clk_sel_slow_o | output | 1 | 1 selects the slow clock |
| dom_en_o | output | 4 | Clock enables: CPU, peripherals, controller, timing/watchdog |
| mode_o | output | 2 | Mode currently in force |

## Verification
A wrong internal phase or target shows at the ports quickly. The enable pattern, the clock select or ready differs from the expected pattern within one to three cycles of the request or wake-up that exposed it, because each step of a transition has a distinct output signature. A miscounted settle wait in stop shows as enables that open one slow tick early or late. A wrongly accepted request shows as a changed mode on the next cycle. The bench compares all four outputs against an independent behavioural model on every clock, so such a divergence is reported in the cycle it first appears.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int N_DOM = 4;

  typedef enum logic [1:0] {
    PM_FULL  = 2'b00,
    PM_SAVE  = 2'b01,
    PM_SLEEP = 2'b10,
    PM_STOP  = 2'b11
  } pm_mode_e;

  typedef enum logic [1:0] {
    PH_STEADY = 2'b00,
    PH_CLOSE  = 2'b01,
    PH_SWAP   = 2'b10,
    PH_SETTLE = 2'b11
  } pm_phase_e;

  // Enable bit order: 0 CPU, 1 peripherals, 2 controller, 3 timing/watchdog
  function automatic logic [N_DOM-1:0] dom_mask(pm_mode_e m);
    case (m)
      PM_FULL:  return 4'b1111;
      PM_SAVE:  return 4'b1111;
      PM_SLEEP: return 4'b1100;
      default:  return 4'b0000;
    endcase
  endfunction

  function automatic logic on_slow(pm_mode_e m);
    return (m != PM_FULL);
  endfunction

endpackage

// File: rtl/pmc_req_check.sv
module pmc_req_check
  import pmc_pkg::*;
(
  input  logic     req_fire_i,
  input  logic [1:0] req_mode_i,
  input  pm_mode_e cur_mode_i,
  output logic     req_take_o,
  output pm_mode_e req_tgt_o
);

  logic from_awake;
  logic differs;

  always_comb begin
    req_tgt_o  = pm_mode_e'(req_mode_i);
    from_awake = (cur_mode_i == PM_FULL) || (cur_mode_i == PM_SAVE);
    differs    = (req_tgt_o != cur_mode_i);
    req_take_o = req_fire_i && from_awake && differs;
  end

endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed_i,
  input  logic              tick_i,
  input  logic [STAB_W-1:0] len_i,
  output logic              done_o
);

  localparam int CW = STAB_W + 1;

  logic [STAB_W-1:0] cnt_q;
  logic [CW-1:0]     cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + CW'(1);
  assign done_o = armed_i && tick_i && (cnt_nx == {1'b0, len_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!armed_i)     cnt_q <= '0;
    else if (tick_i)       cnt_q <= cnt_nx[STAB_W-1:0];
  end

  // R9: while waiting, the count of ticks seen stays below the programmed length
  a_r9_count_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && $stable(len_i)) |-> (cnt_q < len_i));

endmodule

// File: rtl/pmc_dom_gates.sv
module pmc_dom_gates
  import pmc_pkg::*;
(
  input  pm_phase_e        phase_i,
  input  pm_mode_e         mode_i,
  input  pm_mode_e         tgt_i,
  output logic [N_DOM-1:0] dom_en_o,
  output logic             clk_sel_slow_o
);

  logic [N_DOM-1:0] mask;
  logic             steady;

  assign mask   = dom_mask(mode_i);
  assign steady = (phase_i == PH_STEADY);

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign dom_en_o[d] = steady && mask[d];
  end

  assign clk_sel_slow_o = (phase_i == PH_SWAP) ? on_slow(tgt_i) : on_slow(mode_i);

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_take_i,
  input  pm_mode_e  req_tgt_i,
  input  logic      wake_i,
  input  logic      settle_zero_i,
  input  logic      settle_done_i,
  output pm_mode_e  mode_o,
  output pm_mode_e  tgt_o,
  output pm_phase_e phase_o
);

  pm_mode_e  mode_q, mode_d, tgt_q, tgt_d;
  pm_phase_e phase_q, phase_d;

  always_comb begin
    mode_d  = mode_q;
    tgt_d   = tgt_q;
    phase_d = phase_q;
    case (phase_q)
      PH_STEADY: begin
        if (req_take_i) begin
          if (on_slow(req_tgt_i) == on_slow(mode_q)) begin
            mode_d = req_tgt_i;
          end else begin
            tgt_d   = req_tgt_i;
            phase_d = PH_CLOSE;
          end
        end else if (wake_i && mode_q == PM_SLEEP) begin
          tgt_d   = PM_FULL;
          phase_d = PH_CLOSE;
        end else if (wake_i && mode_q == PM_STOP) begin
          tgt_d   = PM_FULL;
          phase_d = settle_zero_i ? PH_CLOSE : PH_SETTLE;
        end
      end
      PH_CLOSE:  phase_d = PH_SWAP;
      PH_SWAP: begin
        mode_d  = tgt_q;
        phase_d = PH_STEADY;
      end
      default: if (settle_done_i) phase_d = PH_CLOSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PM_FULL;
      tgt_q   <= PM_FULL;
      phase_q <= PH_STEADY;
    end else begin
      mode_q  <= mode_d;
      tgt_q   <= tgt_d;
      phase_q <= phase_d;
    end
  end

  assign mode_o  = mode_q;
  assign tgt_o   = tgt_q;
  assign phase_o = phase_q;

  // R8/R9/R10: the low-power modes are left only towards full speed
  a_r10_exit_to_full: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mode_q) == PM_SLEEP || $past(mode_q) == PM_STOP) && mode_q != $past(mode_q))
      |-> (mode_q == PM_FULL));

  // R5: a same-clock change of mode happens only from a steady phase
  a_r5_direct_from_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q) && $past(phase_q) != PH_SWAP)
      |-> ($past(phase_q) == PH_STEADY && phase_q == PH_STEADY));

endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [1:0]        req_mode_i,
  output logic              req_ready_o,
  input  logic              wake_i,
  input  logic              slow_tick_i,
  input  logic [STAB_W-1:0] settle_len_i,
  output logic              clk_sel_slow_o,
  output logic [3:0]        dom_en_o,
  output logic [1:0]        mode_o
);

  pm_mode_e  cur_mode, tgt_mode, req_tgt;
  pm_phase_e phase;
  logic      req_take, settle_done, settle_zero;

  assign req_ready_o = (phase == PH_STEADY);
  assign settle_zero = (settle_len_i == '0);
  assign mode_o      = cur_mode;

  pmc_req_check u_check (
    .req_fire_i (req_valid_i && req_ready_o),
    .req_mode_i (req_mode_i),
    .cur_mode_i (cur_mode),
    .req_take_o (req_take),
    .req_tgt_o  (req_tgt)
  );

  pmc_settle_timer #(.STAB_W(STAB_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed_i (phase == PH_SETTLE),
    .tick_i  (slow_tick_i),
    .len_i   (settle_len_i),
    .done_o  (settle_done)
  );

  pmc_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_take_i    (req_take),
    .req_tgt_i     (req_tgt),
    .wake_i        (wake_i),
    .settle_zero_i (settle_zero),
    .settle_done_i (settle_done),
    .mode_o        (cur_mode),
    .tgt_o         (tgt_mode),
    .phase_o       (phase)
  );

  pmc_dom_gates u_gates (
    .phase_i        (phase),
    .mode_i         (cur_mode),
    .tgt_i          (tgt_mode),
    .dom_en_o       (dom_en_o),
    .clk_sel_slow_o (clk_sel_slow_o)
  );

  // R7: the select moves only inside a window of closed enables
  a_r7_sel_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_slow_o != $past(clk_sel_slow_o)) |-> (dom_en_o == '0 && $past(dom_en_o) == '0));

  // R9: the settle wait in stop ends only on a slow tick
  a_r9_settle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_SETTLE && phase == PH_CLOSE) |-> $past(slow_tick_i));

  // R2: in steady stop every enable is closed
  a_r2_stop_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) |-> (dom_en_o == 4'b0000));

  // R3: an offer while ready is low leaves the mode untouched on the next edge unless a swap completes
  a_r3_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_ready_o && phase != PH_SWAP) |=> $stable(mode_o));

endmodule

// File: tb/pmc_top_tb_top.sv
module pmc_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STAB_W     = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [1:0]        req_mode_i = 2'b00;
  logic              req_ready_o;
  logic              wake_i = 1'b0;
  logic              slow_tick_i = 1'b0;
  logic [STAB_W-1:0] settle_len_i = '0;
  logic              clk_sel_slow_o;
  logic [3:0]        dom_en_o;
  logic [1:0]        mode_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference: mode, phase (0 steady, 1 closed, 2 swap, 3 settle), target, ticks
  int m_mode = 0, m_phase = 0, m_tgt = 0, m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmc_top #(.STAB_W(STAB_W)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid_i),
    .req_mode_i     (req_mode_i),
    .req_ready_o    (req_ready_o),
    .wake_i         (wake_i),
    .slow_tick_i    (slow_tick_i),
    .settle_len_i   (settle_len_i),
    .clk_sel_slow_o (clk_sel_slow_o),
    .dom_en_o       (dom_en_o),
    .mode_o         (mode_o)
  );

  function automatic bit slow_of(int m);
    return m != 0;
  endfunction

  function automatic logic [3:0] en_of(int m);
    if (m <= 1) return 4'b1111;
    if (m == 2) return 4'b1100;
    return 4'b0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_phase = 0; m_tgt = 0; m_cnt = 0;
    end else begin
      case (m_phase)
        0: begin
          if (req_valid_i && m_mode <= 1 && int'(req_mode_i) != m_mode) begin
            if (slow_of(int'(req_mode_i)) == slow_of(m_mode)) m_mode = int'(req_mode_i);
            else begin m_tgt = int'(req_mode_i); m_phase = 1; end
          end else if (wake_i && m_mode == 2) begin
            m_tgt = 0; m_phase = 1;
          end else if (wake_i && m_mode == 3) begin
            m_tgt = 0; m_cnt = 0;
            m_phase = (settle_len_i == 0) ? 1 : 3;
          end
        end
        1: m_phase = 2;
        2: begin m_mode = m_tgt; m_phase = 0; end
        default: if (slow_tick_i) begin
          if (m_cnt + 1 == int'(settle_len_i)) m_phase = 1;
          else m_cnt = m_cnt + 1;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] e_en;
      logic       e_sel;
      logic       e_rdy;
      e_en  = (m_phase == 0) ? en_of(m_mode) : 4'b0000;
      e_sel = (m_phase == 2) ? slow_of(m_tgt) : slow_of(m_mode);
      e_rdy = (m_phase == 0);
      n_cmp++;
      if (dom_en_o !== e_en || clk_sel_slow_o !== e_sel || req_ready_o !== e_rdy ||
          mode_o !== 2'(m_mode)) begin
        n_bad++;
        $display("FAIL %s: en=%b sel=%b rdy=%b mode=%0d expected en=%b sel=%b rdy=%b mode=%0d",
                 cur_req, dom_en_o, clk_sel_slow_o, req_ready_o, mode_o,
                 e_en, e_sel, e_rdy, m_mode);
      end
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ask(logic [1:0] m);
    @(negedge clk);
    req_valid_i = 1'b1; req_mode_i = m;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick_i = 1'b1;
      @(negedge clk); slow_tick_i = 1'b0;
      wait_cyc(gap);
    end
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    cur_req = "R1"; wait_cyc(2);
    cur_req = "R4"; ask(2'b00); wait_cyc(2);          // same mode: ignored
    cur_req = "R6"; ask(2'b01); wait_cyc(5);          // full -> reduced, clock change
    cur_req = "R5"; ask(2'b10); wait_cyc(3);          // reduced -> sleep, same clock
    cur_req = "R10"; ask(2'b00); wait_cyc(2);         // request in sleep ignored
    cur_req = "R8"; pulse_wake(); wait_cyc(5);        // sleep -> full
    cur_req = "R8"; pulse_wake(); wait_cyc(2);        // wake in full ignored
    cur_req = "R3"; ask(2'b10);                       // full -> sleep, then offer while busy
    req_valid_i = 1'b1; req_mode_i = 2'b01;
    @(negedge clk); req_valid_i = 1'b0; wait_cyc(4);
    cur_req = "R8"; pulse_wake();                     // wake, then wake again mid-flight
    wake_i = 1'b1; @(negedge clk); wake_i = 1'b0; wait_cyc(4);
    cur_req = "R2"; ask(2'b11); wait_cyc(4);          // full -> stop
    cur_req = "R10"; ask(2'b01); wait_cyc(2);
    cur_req = "R9"; settle_len_i = 8'd3; pulse_wake();
    ticks(3, 2); wait_cyc(5);
    cur_req = "R6"; ask(2'b01); wait_cyc(4);
    cur_req = "R5"; ask(2'b11); wait_cyc(3);          // reduced -> stop direct
    cur_req = "R9"; settle_len_i = 8'd0; pulse_wake(); wait_cyc(5);
    cur_req = "R9"; ask(2'b11); wait_cyc(4);
    settle_len_i = 8'd1; slow_tick_i = 1'b1; wait_cyc(3);   // ticks before wake do not count
    slow_tick_i = 1'b0; pulse_wake(); wait_cyc(3); ticks(1, 0); wait_cyc(5);
    cur_req = "R7"; ask(2'b01); wait_cyc(4); ask(2'b00); wait_cyc(4);
    cur_req = "R4"; ask(2'b01); wait_cyc(4); ask(2'b01); wait_cyc(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run hung at cycle %0d expected end before 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule